// File: doc/BRIEF.md
# Lane-Confined Packed Byte Shuffler

This block rearranges the bytes of a wide data operand under the direction of a control operand of the same width. Each result byte is either forced to zero or copied from one byte of the data operand. The control byte in the same position as the result byte makes that choice. Selection is confined to 128-bit lanes: a result byte in a lane can only take bytes from the same lane of the data operand. Several result bytes may pick the same source byte, so the result does not have to be a permutation.

A 2-bit mode input decides what happens above the lowest lane. The upper lanes can keep a prior destination value supplied alongside the operands. They can be cleared. They can also be shuffled independently with their own control bytes. The operands are captured when `in_valid` is high. The result appears in one output register with a matching valid flag one clock later. The control operand is only read; the block has no path that writes it back.

Top module: `lane_byte_permuter`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_result` is all zeros.
- R2: A cycle with `in_valid` high produces `out_valid` = 1 and the new result after the next rising clock edge. A cycle with `in_valid` low produces `out_valid` = 0 after that edge, and `out_result` keeps its previous value.
- R3: When bit 7 of a control byte is 1, the result byte at the same position is 0x00, whatever the data operand holds.
- R4: When bit 7 of a control byte is 0, only bits [3:0] of that byte form the index. Bits [6:4] have no effect on the result.
- R5: Result byte i of the lowest lane (bits i*8+7..i*8, i = 0..15) equals data byte `index` taken from data bits 127:0.
- R6: With mode 2'b10, result byte 16+i equals data byte 16+index. Both the index and the zero flag come from control byte 16+i.
- R7: With mode 2'b00, result bits 255:128 equal bits 255:128 of `in_prior` as sampled.
- R8: With mode 2'b01, result bits 255:128 are zero.
- R9: Mode 2'b11 behaves exactly like mode 2'b01: result bits 255:128 are zero, and the lowest lane is still shuffled.
- R10: Any number of result bytes may select the same source byte. A control operand holding the same index in every byte broadcasts that one byte across its lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| in_valid | input | 1 | Operands and mode are sampled on this cycle |
| in_mode | input | 2 | Upper-lane handling: 00 keep prior, 01 clear, 10 shuffle, 11 clear |
| in_data | input | 256 | Data operand whose bytes are selected |
| in_ctrl | input | 256 | Control operand, one control byte per result byte |
| in_prior | input | 256 | Prior destination value, kept above the lowest lane in mode 00 |
| out_valid | output | 1 | Result register holds a result captured on the previous edge |
| out_result | output | 256 | Registered shuffle result |

## Verification
The bench builds the block with its default parameters: 16 bytes per lane, two lanes and 8-bit bytes. This width lets a 4-bit index reach every byte of a lane, and it leaves bits [6:4] of each control byte free to be set as don't-care bits. With two lanes, every mode is visible. So is any leak of a byte across the 128-bit boundary. Directed identity, zero-flag and broadcast masks are combined with seeded random operands across all four mode codes. Idle cycles between results test that the output register holds its value.

// File: rtl/lbp_pkg.sv
package lbp_pkg;

  // Mode codes seen on the in_mode port
  typedef enum logic [1:0] {
    MODE_KEEP_HI  = 2'b00,
    MODE_CLEAR_HI = 2'b01,
    MODE_SHUF_ALL = 2'b10,
    MODE_RSVD     = 2'b11
  } lbp_mode_e;

  // What each lane above the lowest one does with its result
  typedef enum logic [1:0] {
    HI_FROM_PRIOR = 2'b00,
    HI_ZERO       = 2'b01,
    HI_SHUFFLE    = 2'b10
  } hi_policy_e;

  function automatic hi_policy_e decode_mode(input logic [1:0] mode);
    hi_policy_e pol;
    case (lbp_mode_e'(mode))
      MODE_KEEP_HI:  pol = HI_FROM_PRIOR;
      MODE_SHUF_ALL: pol = HI_SHUFFLE;
      default:       pol = HI_ZERO;   // clear and reserved codes
    endcase
    return pol;
  endfunction

endpackage

// File: rtl/lbp_lane_xbar.sv
// One lane of byte selection: each output byte picks a byte of the same lane
// or is forced to zero by the top bit of its control byte.
module lbp_lane_xbar #(
  parameter int LANE_BYTES = 16,
  parameter int BYTE_W     = 8
) (
  input  logic [LANE_BYTES*BYTE_W-1:0] lane_data,
  input  logic [LANE_BYTES*BYTE_W-1:0] lane_ctrl,
  output logic [LANE_BYTES*BYTE_W-1:0] lane_out
);

  localparam int IDX_W  = $clog2(LANE_BYTES);
  localparam int ZF_BIT = BYTE_W - 1;

  logic [LANE_BYTES-1:0][BYTE_W-1:0] data_b;
  logic [LANE_BYTES-1:0][BYTE_W-1:0] ctrl_b;
  logic [LANE_BYTES-1:0][BYTE_W-1:0] out_b;

  assign data_b = lane_data;
  assign ctrl_b = lane_ctrl;

  for (genvar b = 0; b < LANE_BYTES; b++) begin : g_byte
    logic [IDX_W-1:0]  sel_idx;
    logic              zero_flag;
    logic [BYTE_W-1:0] picked;

    // Only the low index bits matter; the bits between them and the
    // zero flag are left unused on purpose.
    assign sel_idx   = ctrl_b[b][IDX_W-1:0];
    assign zero_flag = ctrl_b[b][ZF_BIT];
    assign picked    = data_b[sel_idx];
    assign out_b[b]  = zero_flag ? '0 : picked;
  end

  assign lane_out = out_b;

endmodule

// File: rtl/lbp_lane_policy.sv
// Result selection for one lane above the lowest: prior value, zero or shuffle.
module lbp_lane_policy
  import lbp_pkg::*;
#(
  parameter int LANE_W = 128
) (
  input  hi_policy_e        policy,
  input  logic [LANE_W-1:0] shuf_val,
  input  logic [LANE_W-1:0] prior_val,
  output logic [LANE_W-1:0] lane_res
);

  always_comb begin
    case (policy)
      HI_FROM_PRIOR: lane_res = prior_val;
      HI_SHUFFLE:    lane_res = shuf_val;
      default:       lane_res = '0;
    endcase
  end

endmodule

// File: rtl/lbp_out_stage.sv
// Output register with valid flag; the result updates only on a load cycle.
module lbp_out_stage #(
  parameter int DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] res_in,
  output logic              valid_q,
  output logic [DATA_W-1:0] res_q
);

  logic              valid_d;
  logic [DATA_W-1:0] res_d;
  logic              res_en;

  // Next-state logic
  always_comb begin
    valid_d = load;
    res_en  = load;
    res_d   = res_in;
  end

  // Valid flag register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  // Result register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  // R2
  valid_follows_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid_q);

  // R2
  idle_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> !valid_q);

  // R2
  idle_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(res_q));

endmodule

// File: rtl/lane_byte_permuter.sv
// Lane-confined byte shuffler with selectable upper-lane handling and one
// registered output stage. NUM_LANES must be at least 2.
module lane_byte_permuter
  import lbp_pkg::*;
#(
  parameter int LANE_BYTES = 16,
  parameter int BYTE_W     = 8,
  parameter int NUM_LANES  = 2,
  localparam int LANE_W    = LANE_BYTES * BYTE_W,
  localparam int TOT_W     = LANE_W * NUM_LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_mode,
  input  logic [TOT_W-1:0] in_data,
  input  logic [TOT_W-1:0] in_ctrl,
  input  logic [TOT_W-1:0] in_prior,
  output logic             out_valid,
  output logic [TOT_W-1:0] out_result
);

  hi_policy_e       policy;
  logic [TOT_W-1:0] shuf_all;
  logic [TOT_W-1:0] res_next;

  assign policy = decode_mode(in_mode);

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    lbp_lane_xbar #(
      .LANE_BYTES (LANE_BYTES),
      .BYTE_W     (BYTE_W)
    ) u_xbar (
      .lane_data (in_data[l*LANE_W +: LANE_W]),
      .lane_ctrl (in_ctrl[l*LANE_W +: LANE_W]),
      .lane_out  (shuf_all[l*LANE_W +: LANE_W])
    );

    if (l == 0) begin : g_base
      // The lowest lane is always shuffled
      assign res_next[LANE_W-1:0] = shuf_all[LANE_W-1:0];
    end else begin : g_upper
      lbp_lane_policy #(
        .LANE_W (LANE_W)
      ) u_policy (
        .policy    (policy),
        .shuf_val  (shuf_all[l*LANE_W +: LANE_W]),
        .prior_val (in_prior[l*LANE_W +: LANE_W]),
        .lane_res  (res_next[l*LANE_W +: LANE_W])
      );
    end
  end

  lbp_out_stage #(
    .DATA_W (TOT_W)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (in_valid),
    .res_in  (res_next),
    .valid_q (out_valid),
    .res_q   (out_result)
  );

  // R3
  zero_flag_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ctrl[BYTE_W-1]) |=> (out_result[BYTE_W-1:0] == '0));

  // R6
  zero_flag_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b10 && in_ctrl[LANE_W+BYTE_W-1])
      |=> (out_result[LANE_W +: BYTE_W] == '0));

  // R7
  keep_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b00)
      |=> (out_result[TOT_W-1:LANE_W] == $past(in_prior[TOT_W-1:LANE_W])));

  // R8
  clear_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b01) |=> (out_result[TOT_W-1:LANE_W] == '0));

  // R9
  rsvd_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'b11) |=> (out_result[TOT_W-1:LANE_W] == '0));

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_state_chk: assert (out_valid == 1'b0 || $isunknown(out_valid));
    end
  end

endmodule

// File: tb/test_lane_byte_permuter.sv
module test_lane_byte_permuter;

  localparam int W = 256;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   in_mode;
  logic [W-1:0] in_data;
  logic [W-1:0] in_ctrl;
  logic [W-1:0] in_prior;
  logic         out_valid;
  logic [W-1:0] out_result;

  int checks;
  int fails;
  bit done;

  lane_byte_permuter i_lane_byte_permuter (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_mode    (in_mode),
    .in_data    (in_data),
    .in_ctrl    (in_ctrl),
    .in_prior   (in_prior),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  // 50 MHz clock
  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference model built from the requirements
  function automatic logic [W-1:0] model(input logic [W-1:0] d,
                                         input logic [W-1:0] c,
                                         input logic [W-1:0] p,
                                         input logic [1:0]   m);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) begin
      if (!c[i*8+7]) r[i*8 +: 8] = d[int'(c[i*8 +: 4])*8 +: 8];
    end
    case (m)
      2'b00: r[255:128] = p[255:128];
      2'b10: begin
        for (int i = 0; i < 16; i++) begin
          if (!c[128+i*8+7]) r[128+i*8 +: 8] = d[128 + int'(c[128+i*8 +: 4])*8 +: 8];
        end
      end
      default: r[255:128] = '0;
    endcase
    return r;
  endfunction

  function automatic logic [W-1:0] rnd256();
    logic [W-1:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [W-1:0] fill_bytes(input logic [7:0] b);
    logic [W-1:0] v;
    for (int k = 0; k < 32; k++) v[k*8 +: 8] = b;
    return v;
  endfunction

  // Identity mask: byte i holds index i (mod 16), optional extra bits 6:4
  function automatic logic [W-1:0] ident_mask(input logic [2:0] junk);
    logic [W-1:0] v;
    for (int k = 0; k < 32; k++) v[k*8 +: 8] = {1'b0, junk, 4'(k % 16)};
    return v;
  endfunction

  task automatic check_vec(input string req, input logic [W-1:0] act,
                           input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  logic [W-1:0] last_exp;

  // Drive at falling edge, check at the following falling edge
  task automatic run_op(input string req, input logic [W-1:0] d,
                        input logic [W-1:0] c, input logic [W-1:0] p,
                        input logic [1:0] m);
    logic [W-1:0] exp;
    exp      = model(d, c, p, m);
    in_data  = d;
    in_ctrl  = c;
    in_prior = p;
    in_mode  = m;
    in_valid = 1'b1;
    @(negedge clk);
    check_bit({req, " valid"}, out_valid, 1'b1);
    check_vec(req, out_result, exp);
    last_exp = exp;
  endtask

  task automatic idle_cycle();
    in_valid = 1'b0;
    in_data  = rnd256();
    in_ctrl  = rnd256();
    in_prior = rnd256();
    in_mode  = 2'($urandom);
    @(negedge clk);
    check_bit("R2 idle valid", out_valid, 1'b0);
    check_vec("R2 idle hold", out_result, last_exp);
  endtask

  // Watchdog
  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    logic [W-1:0] p;
    logic [W-1:0] bc;
    logic [W-1:0] e;
    checks   = 0;
    fails    = 0;
    done     = 1'b0;
    void'($urandom(32'd20240611));
    rst_n    = 1'b0;
    in_valid = 1'b1;
    in_mode  = 2'b10;
    in_data  = rnd256();
    in_ctrl  = rnd256();
    in_prior = rnd256();
    repeat (3) @(negedge clk);
    // R1: reset state even while in_valid is high
    check_bit("R1 reset valid", out_valid, 1'b0);
    check_vec("R1 reset result", out_result, '0);
    rst_n    = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    last_exp = '0;
    check_bit("R1 after release valid", out_valid, 1'b0);

    // R5/R6: identity mask returns the data operand
    d = rnd256();
    run_op("R5 R6 identity", d, ident_mask(3'b000), rnd256(), 2'b10);
    check_vec("R5 R6 identity equals data", out_result, d);

    // R4: bits 6:4 set to junk give the same result
    run_op("R4 junk bits", d, ident_mask(3'b111), rnd256(), 2'b10);
    check_vec("R4 junk bits equal data", out_result, d);
    run_op("R4 junk bits 101", d, ident_mask(3'b101), rnd256(), 2'b10);

    // R3: all zero flags give zero result in every lane
    run_op("R3 all zero flags", rnd256(), fill_bytes(8'h80), rnd256(), 2'b10);
    check_vec("R3 all zero flags is zero", out_result, '0);
    run_op("R3 zero flags with index bits", rnd256(), fill_bytes(8'hFF), rnd256(), 2'b10);
    check_vec("R3 0xFF control is zero", out_result, '0);

    // R10: broadcast of byte 5 within each lane
    d  = rnd256();
    bc = fill_bytes(8'h05);
    run_op("R10 broadcast", d, bc, rnd256(), 2'b10);
    e = {fill_bytes(d[128+5*8 +: 8])[127:0], fill_bytes(d[5*8 +: 8])[127:0]};
    check_vec("R10 R6 broadcast lane bytes", out_result, e);

    // R2: idle cycles hold the result
    idle_cycle();
    idle_cycle();

    // R7: keep prior upper lane
    p = rnd256();
    d = rnd256();
    run_op("R7 keep upper", d, ident_mask(3'b000), p, 2'b00);
    check_vec("R7 upper equals prior", {out_result[255:128], 128'h0}, {p[255:128], 128'h0});

    // R8: clear upper lane
    run_op("R8 clear upper", rnd256(), rnd256(), rnd256(), 2'b01);
    check_vec("R8 upper is zero", {out_result[255:128], 128'h0}, '0);

    // R9: reserved code behaves as clear, lower lane still shuffled
    d = rnd256();
    run_op("R9 reserved mode", d, ident_mask(3'b010), rnd256(), 2'b11);
    check_vec("R9 lower shuffled upper zero", out_result, {128'h0, d[127:0]});

    idle_cycle();

    // Random stimulus across every mode, with gaps
    for (int n = 0; n < 400; n++) begin
      logic [1:0] m;
      m = 2'(n % 4);
      case (m)
        2'b00: run_op("R5 R7 random", rnd256(), rnd256(), rnd256(), m);
        2'b01: run_op("R5 R8 random", rnd256(), rnd256(), rnd256(), m);
        2'b10: run_op("R5 R6 R3 random", rnd256(), rnd256(), rnd256(), m);
        default: run_op("R5 R9 random", rnd256(), rnd256(), rnd256(), m);
      endcase
      if ($urandom_range(0, 4) == 0) idle_cycle();
    end

    in_valid = 1'b0;
    done     = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule